// File: doc/BRIEF.md
# Isochronous Receive Quadlet Filter

This block sits between the receive deserializer of a serial-bus link layer and a 32-bit receive FIFO. It takes received quadlets as a valid/ready stream with start-of-packet and end-of-packet flags, and forwards each accepted quadlet unchanged to the FIFO write port. When the cycle-end strobe reports that an isochronous cycle has finished, the block puts one marker quadlet into the same stream. The marker never splits a packet, and it waits rather than being lost when the FIFO is full.

While packets pass through, the block classifies each one. A two-quadlet packet is a PHY configuration packet when two conditions hold: the upper half of its second quadlet is the bitwise inverse of the upper half of its first quadlet, and the lower half of its second quadlet is all ones. Such a packet is forwarded with no destination check. The first 16 bits of a configuration packet can equal this node's bus and node number by chance. That match alone never raises an error and never counts as a hit. Every other packet gets a length sanity check, which can raise a header-error pulse, and a destination compare against the local node ID, which can raise a hit pulse.

Back-pressure rules: a quadlet moves into the FIFO only in a cycle where both `fifo_valid` and `fifo_ready` are high. `in_ready` is low whenever `fifo_ready` is low or the marker holds the write port. The input path has no buffer, so `fifo_valid` and `fifo_data` follow `in_valid` and `in_data` in the same cycle.

Top module: `iso_rx_filter`

## Requirements
- R1: Every input quadlet accepted (`in_valid` and `in_ready` high) appears on `fifo_data` in that same cycle with `fifo_valid` high, bit for bit, in arrival order.
- R2: `in_ready` is low in every cycle in which `fifo_ready` is low, so no quadlet is taken while the FIFO cannot accept it.
- R3: Each cycle-end strobe (`cycle_end` high for one clock) produces exactly one marker write of value 32'h0000_0001, where bit 0 is the cycle-done flag. Up to 3 strobes may be outstanding, and each yields its own marker.
- R4: While a marker is due and `fifo_ready` is low, `fifo_valid` stays high with `fifo_data` = 32'h0000_0001 and `in_ready` low, until the FIFO accepts it.
- R5: A strobe that arrives after a packet's start quadlet and before its end quadlet has been accepted delays the marker until after that end quadlet has been written.
- R6: When a marker is due and no packet is open, the marker takes the write port ahead of a waiting start quadlet, and `in_ready` is low in that cycle.
- R7: A packet of exactly two quadlets whose second quadlet has bits [31:16] equal to the inverse of the first quadlet's bits [31:16] and bits [15:0] equal to 16'hFFFF is a configuration packet. It raises neither `hdr_err` nor `dest_hit`, even when the first quadlet's bits [31:16] equal `node_id`.
- R8: Any other packet with fewer than MIN_DATA_Q (default 3) quadlets raises `hdr_err` for exactly one cycle, in the cycle after its end quadlet is accepted. Packets that pass this check never raise `hdr_err`.
- R9: A non-configuration packet that passes the length check raises `dest_hit` for one cycle, in the cycle after its end quadlet, when two conditions hold. First, bits [21:16] of its first quadlet (the node number) equal `node_id[5:0]`. Second, bits [31:22] (the bus number) equal `node_id[15:6]` or are all ones, which means the local bus.
- R10: After reset `fifo_valid` (with `in_valid` low), `hdr_err` and `dest_hit` are low, no marker is pending, and `in_ready` follows `fifo_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input quadlet valid |
| in_ready | output | 1 | Input quadlet accepted when high with in_valid |
| in_data | input | 32 | Received quadlet |
| in_sop | input | 1 | First quadlet of a packet |
| in_eop | input | 1 | Last quadlet of a packet |
| cycle_end | input | 1 | One-clock strobe: isochronous cycle finished |
| node_id | input | 16 | Local bus number [15:6] and node number [5:0] |
| fifo_valid | output | 1 | FIFO write request |
| fifo_ready | input | 1 | FIFO can take a word this cycle (not full) |
| fifo_data | output | 32 | Word written to the FIFO |
| hdr_err | output | 1 | One-cycle header error pulse |
| dest_hit | output | 1 | One-cycle pulse: packet addressed to this node |

## Verification
A wrong pending-marker count shows up at the FIFO port within one write slot, as a missing, duplicated or early 32'h0000_0001 word in the expected word order. A stale packet-open flag shows up the same way, with the marker placed inside a packet or held back after it. A bad quadlet counter or a bad stored header half shows up on `hdr_err` or `dest_hit` exactly one cycle after the end quadlet. This is checked on configuration packets that alias the node ID, on short and non-matching two-quadlet packets, and on local-bus addresses. Random FIFO stalls test whether the marker and the data survive back-pressure.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
  localparam int QUAD_W  = 32;
  localparam int HALF_W  = 16;
  localparam int BUS_W   = 10;
  localparam int NODE_W  = 6;
  localparam logic [QUAD_W-1:0] CYCLE_MARK = 32'h0000_0001;

  // Second quadlet of a configuration pair: inverse upper half, ones below
  function automatic logic cfg_pair(input logic [HALF_W-1:0] first_hi,
                                    input logic [QUAD_W-1:0] second);
    return (second[QUAD_W-1:HALF_W] == ~first_hi) &&
           (second[HALF_W-1:0] == {HALF_W{1'b1}});
  endfunction

  // Destination compare; an all-ones bus number aliases the local bus
  function automatic logic dest_match(input logic [HALF_W-1:0] dst,
                                      input logic [HALF_W-1:0] me);
    logic bus_ok;
    bus_ok = (dst[HALF_W-1:NODE_W] == me[HALF_W-1:NODE_W]) ||
             (dst[HALF_W-1:NODE_W] == {BUS_W{1'b1}});
    return bus_ok && (dst[NODE_W-1:0] == me[NODE_W-1:0]);
  endfunction
endpackage

// File: rtl/iso_rx_marker.sv
module iso_rx_marker #(
  parameter int PEND_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_end,
  input  logic pkt_open,
  input  logic fifo_ready,
  output logic mk_valid
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] pend;
  logic              add;
  logic              take;

  assign mk_valid = (pend != '0) && !pkt_open;
  assign take     = mk_valid && fifo_ready;
  assign add      = cycle_end && (pend != PEND_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (add && !take) begin
      pend <= pend + 1'b1;
    end else if (take && !add) begin
      pend <= pend - 1'b1;
    end
  end

  AST_MARK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mk_valid && !fifo_ready) |=> mk_valid); // R4
endmodule

// File: rtl/iso_rx_classify.sv
module iso_rx_classify
  import iso_rx_pkg::*;
#(
  parameter int MIN_DATA_Q = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_fire,
  input  logic              sop,
  input  logic              eop,
  input  logic [QUAD_W-1:0] data,
  input  logic [HALF_W-1:0] node_id,
  output logic              hdr_err,
  output logic              dest_hit
);
  localparam int CNT_W = $clog2(MIN_DATA_Q + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_DATA_Q);
  localparam logic [CNT_W:0]   LEN_MIN = (CNT_W+1)'(MIN_DATA_Q);

  logic [HALF_W-1:0] hdr_hi;
  logic [CNT_W-1:0]  cnt;
  logic [HALF_W-1:0] first_hi;
  logic [CNT_W:0]    len_now;
  logic              is_cfg;
  logic              too_short;

  always_comb begin
    first_hi  = sop ? data[QUAD_W-1:HALF_W] : hdr_hi;
    len_now   = sop ? (CNT_W+1)'(1) : ({1'b0, cnt} + 1'b1);
    is_cfg    = !sop && (cnt == CNT_W'(1)) && cfg_pair(hdr_hi, data);
    too_short = len_now < LEN_MIN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_hi   <= '0;
      cnt      <= '0;
      hdr_err  <= 1'b0;
      dest_hit <= 1'b0;
    end else begin
      hdr_err  <= 1'b0;
      dest_hit <= 1'b0;
      if (beat_fire) begin
        if (sop) begin
          hdr_hi <= data[QUAD_W-1:HALF_W];
          cnt    <= CNT_W'(1);
        end else if (cnt != CNT_MAX) begin
          cnt <= cnt + 1'b1;
        end
        if (eop) begin
          hdr_err  <= !is_cfg && too_short;
          dest_hit <= !is_cfg && !too_short && dest_match(first_hi, node_id);
        end
      end
    end
  end

  AST_ERR_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> $past(beat_fire && eop)); // R8
  AST_ERR_HIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_err && dest_hit)); // R9
endmodule

// File: rtl/iso_rx_filter.sv
module iso_rx_filter
  import iso_rx_pkg::*;
#(
  parameter int MIN_DATA_Q = 3,
  parameter int PEND_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [QUAD_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              cycle_end,
  input  logic [HALF_W-1:0] node_id,
  output logic              fifo_valid,
  input  logic              fifo_ready,
  output logic [QUAD_W-1:0] fifo_data,
  output logic              hdr_err,
  output logic              dest_hit
);
  logic mk_valid;
  logic pkt_open;
  logic beat_fire;

  assign in_ready   = fifo_ready && !mk_valid;
  assign beat_fire  = in_valid && in_ready;
  assign fifo_valid = mk_valid || in_valid;
  assign fifo_data  = mk_valid ? CYCLE_MARK : in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_open <= 1'b0;
    end else if (beat_fire) begin
      if (in_eop)      pkt_open <= 1'b0;
      else if (in_sop) pkt_open <= 1'b1;
    end
  end

  iso_rx_marker #(.PEND_W(PEND_W)) u_marker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cycle_end (cycle_end),
    .pkt_open  (pkt_open),
    .fifo_ready(fifo_ready),
    .mk_valid  (mk_valid)
  );

  iso_rx_classify #(.MIN_DATA_Q(MIN_DATA_Q)) u_classify (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_fire(beat_fire),
    .sop      (in_sop),
    .eop      (in_eop),
    .data     (in_data),
    .node_id  (node_id),
    .hdr_err  (hdr_err),
    .dest_hit (dest_hit)
  );

  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (fifo_valid && fifo_data == in_data)); // R1
  AST_MARK_NOT_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sop && !in_eop) |=> !(fifo_valid && !in_ready && fifo_ready)); // R5
endmodule

// File: tb/iso_rx_filter_tb.sv
module iso_rx_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MARK = 32'h0000_0001;
  localparam logic [15:0] MY_ID = {10'h029, 6'h13};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, cycle_end = 1'b0;
  logic [31:0] in_data = '0;
  logic fifo_ready = 1'b1;
  logic in_ready, fifo_valid, hdr_err, dest_hit;
  logic [31:0] fifo_data;
  logic [15:0] node_id = MY_ID;

  int errors = 0;
  int checks = 0;
  bit stall_mode = 1'b0;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_rx_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .cycle_end(cycle_end),
    .node_id(node_id), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
    .fifo_data(fifo_data), .hdr_err(hdr_err), .dest_hit(dest_hit)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit tb_match(input logic [15:0] d);
    return (d[5:0] == MY_ID[5:0]) &&
           ((d[15:6] == MY_ID[15:6]) || (d[15:6] == 10'h3FF));
  endfunction

  // random FIFO back-pressure
  always @(posedge clk) begin
    #1;
    if (stall_mode) fifo_ready = ($urandom % 4) != 0;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_valid && fifo_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected write", fifo_data, 32'hx);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(fifo_data === e, "R1/R3/R5 word order", fifo_data, e);
        end
      end
      if (!fifo_ready) chk(in_ready == 1'b0, "R2 ready while full", {31'b0, in_ready}, 32'h0);
    end
  end

  task automatic wait_accept();
    @(negedge clk);
    while (!in_ready) begin
      @(posedge clk); #1 cycle_end = 1'b0;
      @(negedge clk);
    end
    @(posedge clk); #1 cycle_end = 1'b0;
  endtask

  task automatic send_pkt(input int n, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3,
                          input logic [3:0] smask, input string tag);
    logic [31:0] w [4];
    bit cfg, err, hit;
    w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
    cfg = (n == 2) && (w1[31:16] == ~w0[31:16]) && (w1[15:0] == 16'hFFFF);
    err = !cfg && (n < 3);
    hit = !cfg && !err && tb_match(w0[31:16]);
    for (int i = 0; i < n; i++) exp_q.push_back(w[i]);
    for (int i = 0; i < n; i++) if (smask[i]) exp_q.push_back(MARK);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = w[i]; in_sop = (i == 0); in_eop = (i == n - 1);
      cycle_end = smask[i];
      wait_accept();
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    @(negedge clk);
    chk(hdr_err == err, {tag, " R8 hdr_err"}, {31'b0, hdr_err}, {31'b0, err});
    chk(dest_hit == hit, {tag, " R9 dest_hit"}, {31'b0, dest_hit}, {31'b0, hit});
    @(posedge clk); #1;
  endtask

  task automatic strobe_idle();
    exp_q.push_back(MARK);
    cycle_end = 1'b1;
    @(posedge clk); #1 cycle_end = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(fifo_valid == 1'b0, "R10 fifo_valid", {31'b0, fifo_valid}, 0);
    chk(hdr_err == 1'b0 && dest_hit == 1'b0, "R10 pulses", {30'b0, hdr_err, dest_hit}, 0);
    chk(in_ready == 1'b1, "R10 in_ready", {31'b0, in_ready}, 1);
    @(posedge clk); #1;

    // data packets
    send_pkt(4, 32'h1234_0000, 32'h1, 32'h2, 32'h3, 4'b0, "other node R1");
    send_pkt(3, {MY_ID, 16'h0A10}, 32'hdead_beef, 32'h5, 0, 4'b0, "own node R9");
    send_pkt(3, {10'h3FF, MY_ID[5:0], 16'h0}, 32'h7, 32'h8, 0, 4'b0, "local bus R9");
    send_pkt(3, {10'h3FF, 6'h01, 16'h0}, 32'h7, 32'h8, 0, 4'b0, "local bus other R9");
    send_pkt(1, {MY_ID, 16'h0}, 0, 0, 0, 4'b0, "single R8");
    send_pkt(2, {MY_ID, 16'h00E0}, 32'h0000_FFFF, 0, 0, 4'b0, "two non-cfg R8");
    send_pkt(2, {MY_ID, 16'h00E0}, {~MY_ID, 16'hFFFE}, 0, 0, 4'b0, "cfg bad low R8");
    // configuration packets, one aliasing this node's ID
    send_pkt(2, {MY_ID, 16'h00E0}, {~MY_ID, 16'hFFFF}, 0, 0, 4'b0, "cfg alias R7");
    send_pkt(2, 32'h4C80_0000, 32'hB37F_FFFF, 0, 0, 4'b0, "cfg R7");

    // markers
    strobe_idle();                                                        // R3
    repeat (2) @(posedge clk); #1;
    send_pkt(4, 32'h5555_0000, 1, 2, 3, 4'b0010, "mid strobe R5");
    send_pkt(4, 32'h6666_0000, 1, 2, 3, 4'b1000, "eop strobe R5");
    send_pkt(4, 32'h7777_0000, 1, 2, 3, 4'b0110, "two strobes R3");

    // R6: marker ahead of a waiting start quadlet
    strobe_idle();
    in_valid = 1'b1; in_data = 32'h2222_0000; in_sop = 1'b1; in_eop = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0 && fifo_data == MARK, "R6 marker first", fifo_data, MARK);
    @(posedge clk); #1 in_valid = 1'b0; in_sop = 1'b0;
    send_pkt(3, 32'h2222_0000, 1, 2, 0, 4'b0, "after marker R6");

    // R4: marker held while the FIFO is full
    fifo_ready = 1'b0;
    strobe_idle();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(fifo_valid && fifo_data == MARK && !in_ready, "R4 marker held", fifo_data, MARK);
    end
    @(posedge clk); #1 fifo_ready = 1'b1;
    repeat (2) @(posedge clk); #1;

    // R2: random back-pressure with mixed traffic
    stall_mode = 1'b1;
    for (int k = 0; k < 24; k++) begin
      logic [31:0] a, b;
      int n;
      n = 1 + (k % 4);
      a = $urandom;
      if (k % 3 == 0) a[31:16] = MY_ID;
      b = (k % 5 == 1) ? {~a[31:16], 16'hFFFF} : $urandom;
      send_pkt(n, a, b, $urandom, $urandom, (n > 2) ? 4'b0010 : 4'b0, "stall R2");
    end
    stall_mode = 1'b0;
    #1 fifo_ready = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected written", exp_q.size(), 0);
    chk(fifo_valid == 1'b0, "R3 no extra marker", {31'b0, fifo_valid}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule